// File: doc/BRIEF.md
# Per-Pin Edge and Level Event Detector

This block watches the 32 input pins of a general-purpose port and turns changes on them into requests for the rest of the chip. Every pin has its own 4-bit mode code. The code chooses what to look for and what to do when it is seen. The choices are a rising edge, a falling edge, either edge, a low level or a high level. The actions are to raise a DMA request, to set a status flag only, to raise the shared interrupt, or to drive a trigger line that follows the pin. The mode codes come from outside, from configuration storage that the block does not own. Each pin first passes through a two-flop synchronizer. Edges are found by comparing the synchronized level with its value one cycle earlier.

The block keeps one status flag per pin, and bit n of the status vector belongs to pin n. Software clears flags by writing ones to the status vector. A zero bit in that write leaves the flag as it is. A pin in a DMA mode also has its flag cleared by a per-pin completion pulse from the DMA engine. For a level mode, a flag cleared while the level is still present is set again at once. When a set event and a clear fall in the same cycle, the set wins. All outputs come from registers.

Top module: `pin_event_detector`

## Requirements
- R1: After synchronous reset, the status vector, irq, every dma_req bit and every trig_out bit are 0.
- R2: Mode code 0 sets no flag and drives no output, whatever the pin does.
- R3: Codes 1, 2 and 3 set the pin's flag on a rising edge, a falling edge and either edge respectively. For such a pin, dma_req[n] equals its flag and irq is not raised.
- R4: A dma_done[n] pulse clears flag n when pin n is in a DMA mode (codes 1 to 3). The pulse has no effect on a pin in any other mode.
- R5: Codes 5, 6 and 7 set only the flag, on a rising edge, a falling edge and either edge respectively. They raise neither irq nor dma_req.
- R6: Codes 9, 10 and 11 set the flag on a rising edge, a falling edge and either edge respectively. Code 8 sets it while the pin is 0 and code 12 while the pin is 1.
- R7: irq is 1 exactly when at least one pin in codes 8 to 12 has its flag set.
- R8: A write with clr_wr=1 clears every flag whose clr_data bit is 1 and leaves flags whose bit is 0 unchanged.
- R9: In a level mode (8 or 12), a flag cleared while its level is still present reads 1 again in the cycle after the clear.
- R10: When a set event and a clear (write-one or DMA done) hit the same flag in the same cycle, the flag ends up set.
- R11: Code 13 drives trig_out[n] equal to the synchronized pin level and code 14 drives its inverse. Neither sets a flag. All other codes hold trig_out[n] at 0.
- R12: Codes 4 and 15 are reserved. They set no flag and drive no output.
- R13: Status bit n belongs to pin n. For example, events pending on pins 0 and 16 alone read as 0x00010001.
- R14: A pin change that is stable before clock edge k appears on status, irq, dma_req and trig_out after clock edge k+2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_in | input | 32 | Asynchronous pin levels |
| mode_codes | input | 128 | 4-bit mode code per pin, pin n in bits [4n+3:4n] |
| clr_wr | input | 1 | Write strobe for the clear-by-one status write |
| clr_data | input | 32 | Write data; a 1 clears that pin's flag |
| dma_done | input | 32 | Per-pin DMA transfer completion pulse |
| status | output | 32 | Flag per pin, bit n for pin n |
| irq | output | 1 | OR of the flags of pins in interrupt modes |
| dma_req | output | 32 | Per-pin DMA request |
| trig_out | output | 32 | Per-pin trigger output |

## Verification
A wrong edge register or synchronizer stage shows up in two ways. A flag either appears for the opposite edge, or it appears one cycle earlier or later than two edges after the pin change. The bench samples at that exact point. A faulty flag update shows up on status right after the clear cycle, and the same cycle decides set-over-clear and the re-set of a level flag. A fault in the mode decode shows up within a few cycles as an irq, dma_req or trig_out bit asserted for a mode that should not drive it.

// File: rtl/pin_evt_pkg.sv
package pin_evt_pkg;

  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    MD_OFF      = 4'd0,
    MD_DMA_RISE = 4'd1,
    MD_DMA_FALL = 4'd2,
    MD_DMA_BOTH = 4'd3,
    MD_RSV_A    = 4'd4,
    MD_FLG_RISE = 4'd5,
    MD_FLG_FALL = 4'd6,
    MD_FLG_BOTH = 4'd7,
    MD_INT_LOW  = 4'd8,
    MD_INT_RISE = 4'd9,
    MD_INT_FALL = 4'd10,
    MD_INT_BOTH = 4'd11,
    MD_INT_HIGH = 4'd12,
    MD_TRG_HI   = 4'd13,
    MD_TRG_LO   = 4'd14,
    MD_RSV_B    = 4'd15
  } pin_mode_e;

  typedef struct packed {
    logic on_rise;
    logic on_fall;
    logic on_low;
    logic on_high;
    logic is_dma;
    logic is_irq;
    logic trig_hi;
    logic trig_lo;
  } mode_dec_t;

  function automatic mode_dec_t decode_mode(input logic [MODE_W-1:0] code);
    mode_dec_t d;
    d = '0;
    case (pin_mode_e'(code))
      MD_DMA_RISE: begin d.on_rise = 1'b1; d.is_dma = 1'b1; end
      MD_DMA_FALL: begin d.on_fall = 1'b1; d.is_dma = 1'b1; end
      MD_DMA_BOTH: begin d.on_rise = 1'b1; d.on_fall = 1'b1; d.is_dma = 1'b1; end
      MD_FLG_RISE: d.on_rise = 1'b1;
      MD_FLG_FALL: d.on_fall = 1'b1;
      MD_FLG_BOTH: begin d.on_rise = 1'b1; d.on_fall = 1'b1; end
      MD_INT_LOW:  begin d.on_low  = 1'b1; d.is_irq = 1'b1; end
      MD_INT_RISE: begin d.on_rise = 1'b1; d.is_irq = 1'b1; end
      MD_INT_FALL: begin d.on_fall = 1'b1; d.is_irq = 1'b1; end
      MD_INT_BOTH: begin d.on_rise = 1'b1; d.on_fall = 1'b1; d.is_irq = 1'b1; end
      MD_INT_HIGH: begin d.on_high = 1'b1; d.is_irq = 1'b1; end
      MD_TRG_HI:   d.trig_hi = 1'b1;
      MD_TRG_LO:   d.trig_lo = 1'b1;
      default:     d = '0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] lvl,
  output logic [WIDTH-1:0] lvl_prev
);

  logic [WIDTH-1:0] chain [STAGES];
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[s] <= '0;
      else     chain[s] <= chain[s-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) prev_q <= '0;
    else     prev_q <= chain[STAGES-1];
  end

  assign lvl      = chain[STAGES-1];
  assign lvl_prev = prev_q;

endmodule

// File: rtl/pin_event_cell.sv
module pin_event_cell
  import pin_evt_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              lvl,
  input  logic              lvl_prev,
  input  logic [MODE_W-1:0] mode,
  input  logic              clr_hit,
  input  logic              dma_done,
  output logic              flag_nxt,
  output logic              irq_nxt,
  output logic              flag_q,
  output logic              dma_q,
  output logic              trig_q
);

  mode_dec_t dec;
  logic      rise, fall, set_evt, dma_clr, trig_nxt;

  always_comb begin
    dec      = decode_mode(mode);
    rise     = lvl & ~lvl_prev;
    fall     = ~lvl & lvl_prev;
    set_evt  = (dec.on_rise & rise) | (dec.on_fall & fall) |
               (dec.on_low & ~lvl)  | (dec.on_high & lvl);
    dma_clr  = dma_done & dec.is_dma;
    // A set in the same cycle overrides any clear.
    flag_nxt = set_evt | (flag_q & ~clr_hit & ~dma_clr);
    irq_nxt  = flag_nxt & dec.is_irq;
    trig_nxt = (dec.trig_hi & lvl) | (dec.trig_lo & ~lvl);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      dma_q  <= 1'b0;
      trig_q <= 1'b0;
    end else begin
      flag_q <= flag_nxt;
      dma_q  <= flag_nxt & dec.is_dma;
      trig_q <= trig_nxt;
    end
  end

endmodule

// File: rtl/pin_event_detector.sv
module pin_event_detector
  import pin_evt_pkg::*;
#(
  parameter int NPINS       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NPINS-1:0]        pin_in,
  input  logic [NPINS*MODE_W-1:0] mode_codes,
  input  logic                    clr_wr,
  input  logic [NPINS-1:0]        clr_data,
  input  logic [NPINS-1:0]        dma_done,
  output logic [NPINS-1:0]        status,
  output logic                    irq,
  output logic [NPINS-1:0]        dma_req,
  output logic [NPINS-1:0]        trig_out
);

  logic [NPINS-1:0] lvl, lvl_prev, clr_mask, irq_vec, flag_nxt_vec;
  logic             irq_q;

  pin_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .d        (pin_in),
    .lvl      (lvl),
    .lvl_prev (lvl_prev)
  );

  assign clr_mask = clr_wr ? clr_data : '0;

  for (genvar n = 0; n < NPINS; n++) begin : g_pin
    pin_event_cell u_cell (
      .clk      (clk),
      .rst      (rst),
      .lvl      (lvl[n]),
      .lvl_prev (lvl_prev[n]),
      .mode     (mode_codes[n*MODE_W +: MODE_W]),
      .clr_hit  (clr_mask[n]),
      .dma_done (dma_done[n]),
      .flag_nxt (flag_nxt_vec[n]),
      .irq_nxt  (irq_vec[n]),
      .flag_q   (status[n]),
      .dma_q    (dma_req[n]),
      .trig_q   (trig_out[n])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= |irq_vec;
  end

  assign irq = irq_q;

endmodule

// File: rtl/pin_event_detector_chk.sv
module pin_event_detector_chk
  import pin_evt_pkg::*;
#(
  parameter int NPINS = 32
) (
  input logic                    clk,
  input logic                    rst,
  input logic [NPINS*MODE_W-1:0] mode_codes,
  input logic                    clr_wr,
  input logic [NPINS-1:0]        clr_data,
  input logic [NPINS-1:0]        dma_done,
  input logic [NPINS-1:0]        status,
  input logic                    irq,
  input logic [NPINS-1:0]        dma_req,
  input logic [NPINS-1:0]        trig_out
);

  logic [NPINS-1:0] wmask, trig_ok, noflag, dma_mode;

  always_comb begin
    wmask = clr_wr ? clr_data : '0;
    for (int n = 0; n < NPINS; n++) begin
      mode_dec_t d;
      d = decode_mode(mode_codes[n*MODE_W +: MODE_W]);
      trig_ok[n]  = d.trig_hi | d.trig_lo;
      noflag[n]   = ~(d.on_rise | d.on_fall | d.on_low | d.on_high);
      dma_mode[n] = d.is_dma;
    end
  end

  // R8: a flag drops only through a write-one or a DMA completion
  a_r8_flag_holds: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (($past(status) & ~$past(wmask) & ~($past(dma_done) & $past(dma_mode)) & ~status) == '0));

  // R7: irq never stands without a pending flag
  a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (rst)
    irq |-> (status != '0));

  // R3: a DMA request is always backed by its flag
  a_r3_dma_backed: assert property (@(posedge clk) disable iff (rst)
    (dma_req & ~status) == '0);

  // R11: trigger bits come only from trigger modes
  a_r11_trig_mode: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((trig_out & ~$past(trig_ok)) == '0));

  // R12: modes that detect nothing never set a new flag
  a_r12_no_new_flag: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status & ~$past(status) & $past(noflag)) == '0));

endmodule

bind pin_event_detector pin_event_detector_chk #(.NPINS(NPINS)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mode_codes (mode_codes),
  .clr_wr     (clr_wr),
  .clr_data   (clr_data),
  .dma_done   (dma_done),
  .status     (status),
  .irq        (irq),
  .dma_req    (dma_req),
  .trig_out   (trig_out)
);

// File: tb/pin_event_detector_bench.sv
`timescale 1ns/1ps
module pin_event_detector_bench;

  localparam int NP = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP-1:0] pin_in = '0;
  logic [NP*4-1:0] mode_codes = '0;
  logic          clr_wr = 1'b0;
  logic [NP-1:0] clr_data = '0;
  logic [NP-1:0] dma_done = '0;
  logic [NP-1:0] status, dma_req, trig_out;
  logic          irq;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  pin_event_detector u_pin_event_detector (
    .clk(clk), .rst(rst), .pin_in(pin_in), .mode_codes(mode_codes),
    .clr_wr(clr_wr), .clr_data(clr_data), .dma_done(dma_done),
    .status(status), .irq(irq), .dma_req(dma_req), .trig_out(trig_out)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_mode(input int pin, input logic [3:0] code);
    mode_codes[pin*4 +: 4] = code;
  endtask

  task automatic w1c(input logic [31:0] mask);
    clr_wr = 1'b1; clr_data = mask;
    tick(1);
    clr_wr = 1'b0; clr_data = '0;
  endtask

  task automatic dma_pulse(input logic [31:0] mask);
    dma_done = mask;
    tick(1);
    dma_done = '0;
  endtask

  task automatic clean();
    mode_codes = '0;
    tick(1);
    w1c('1);
    tick(1);
  endtask

  task automatic t_reset();
    chk("R1 status", status, 0);
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 dma_req", dma_req, 0);
    chk("R1 trig_out", trig_out, 0);
  endtask

  task automatic t_off();
    pin_in[0] = 1'b1; tick(4);
    pin_in[0] = 1'b0; tick(4);
    chk("R2 code0 status", status, 0);
    chk("R2 code0 irq", {31'd0, irq}, 0);
  endtask

  task automatic t_dma();
    set_mode(1, 4'd1); set_mode(2, 4'd2); set_mode(3, 4'd3);
    tick(1);
    pin_in[3:1] = 3'b111; tick(3);
    chk("R14 latency rise", status, 32'h0000_000A);
    chk("R3 dma_req", dma_req, 32'h0000_000A);
    chk("R3 no irq", {31'd0, irq}, 0);
    dma_pulse(32'h0000_0002);
    chk("R4 dma_done clears", status, 32'h0000_0008);
    w1c(32'h8);
    pin_in[3:1] = 3'b000; tick(4);
    chk("R3 falling codes", status, 32'h0000_000C);
    chk("R3 dma_req fall", dma_req, 32'h0000_000C);
    dma_pulse(32'h0000_000C);
    chk("R4 dma_done clears both", status, 0);
    clean();
  endtask

  task automatic t_flag_only();
    set_mode(10, 4'd5); set_mode(11, 4'd6); set_mode(12, 4'd7);
    tick(1);
    pin_in[12:10] = 3'b111; tick(4);
    chk("R5 flag-only rise", status, 32'h0000_1400);
    chk("R5 no irq", {31'd0, irq}, 0);
    chk("R5 no dma", dma_req, 0);
    dma_pulse(32'h0000_1C00);
    chk("R4 dma_done ignored", status, 32'h0000_1400);
    w1c(32'h0);
    chk("R8 zero write no effect", status, 32'h0000_1400);
    w1c(32'h0000_0400);
    chk("R8 clears only ones", status, 32'h0000_1000);
    pin_in[12:10] = 3'b000; tick(4);
    chk("R5 flag-only fall", status, 32'h0000_1800);
    clean();
  endtask

  task automatic t_int_edge();
    set_mode(20, 4'd9); set_mode(21, 4'd10); set_mode(22, 4'd11);
    tick(1);
    pin_in[22:20] = 3'b111; tick(3);
    chk("R6 int rise", status, 32'h0050_0000);
    chk("R7 irq set", {31'd0, irq}, 1);
    w1c(32'h0050_0000);
    chk("R7 irq drops", {31'd0, irq}, 0);
    pin_in[22:20] = 3'b000; tick(4);
    chk("R6 int fall", status, 32'h0060_0000);
    clean();
  endtask

  task automatic t_pattern();
    set_mode(0, 4'd9); set_mode(16, 4'd9);
    tick(1);
    pin_in[0] = 1'b1; pin_in[16] = 1'b1; tick(4);
    chk("R13 pins 0 and 16", status, 32'h0001_0001);
    w1c(32'h1);
    chk("R13 pin 16 left", status, 32'h0001_0000);
    pin_in[0] = 1'b0; pin_in[16] = 1'b0;
    clean();
  endtask

  task automatic t_level();
    set_mode(6, 4'd8);
    tick(2);
    chk("R6 low level", status, 32'h40);
    chk("R7 irq level", {31'd0, irq}, 1);
    w1c(32'h40);
    chk("R9 level re-sets", status, 32'h40);
    pin_in[6] = 1'b1; tick(4);
    w1c(32'h40);
    chk("R9 clear after level gone", status, 0);
    chk("R7 irq gone", {31'd0, irq}, 0);
    set_mode(7, 4'd12);
    tick(2);
    chk("R6 high idle", status, 0);
    pin_in[7] = 1'b1; tick(4);
    chk("R6 high level", status, 32'h80);
    pin_in[7:6] = 2'b00;
    clean();
  endtask

  task automatic t_set_wins();
    set_mode(4, 4'd11);
    tick(1);
    pin_in[4] = 1'b1; tick(4);
    pin_in[4] = 1'b0;
    tick(2);
    w1c(32'h10);
    chk("R10 set beats clear", status, 32'h10);
    w1c(32'h10);
    chk("R10 plain clear", status, 0);
    clean();
  endtask

  task automatic t_trig();
    set_mode(8, 4'd13); set_mode(9, 4'd14);
    tick(2);
    chk("R11 trig idle", trig_out, 32'h200);
    pin_in[9:8] = 2'b11; tick(3);
    chk("R11 trig follow", trig_out, 32'h100);
    chk("R11 no flag", status, 0);
    pin_in[9:8] = 2'b00;
    clean();
    chk("R11 trig off", trig_out, 0);
  endtask

  task automatic t_reserved();
    set_mode(13, 4'd4); set_mode(14, 4'd15);
    tick(1);
    pin_in[14:13] = 2'b11; tick(4);
    pin_in[14:13] = 2'b00; tick(4);
    chk("R12 reserved status", status, 0);
    chk("R12 reserved dma", dma_req, 0);
    chk("R12 reserved trig", trig_out, 0);
    chk("R12 reserved irq", {31'd0, irq}, 0);
    clean();
  endtask

  initial begin
    tick(3);
    t_reset();
    rst = 1'b0;
    tick(2);
    t_reset();
    t_off();
    t_dma();
    t_flag_only();
    t_int_edge();
    t_pattern();
    t_level();
    t_set_wins();
    t_trig();
    t_reserved();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule